// File: doc/BRIEF.md
# Stack Pointer Unit

This block holds the 16-bit stack pointer of a small 8-bit processor core and presents the address for stack memory accesses. The pointer always names the next free stack slot, so a store to the stack uses the pointer as it stands and then steps it down. A read from the stack steps the pointer up first and then uses the new value. It can also move the pointer by a signed byte, to open or close a frame of local variables. It can be loaded with a full 16-bit value during initialisation, and it can re-seed only its low byte for compatibility with older code.

The control inputs are plain single-cycle strobes that the core's sequencer is expected to raise one at a time. A full load wins over anything else raised in the same cycle. Any other overlap of strobes is flagged on a status pin, and the pointer keeps its value. There is no data stream at this block's edge, so no valid/ready handshake applies. The address output is combinational, so the sequencer can use it in the same cycle it raises a strobe. Reset is synchronous and active high.

Top module: `stack_ptr_unit`

## Requirements
- R1: A clock edge with `rst` high sets the pointer to 0x00FF, whatever strobes are raised.
- R2: With `push_i` as the only strobe, `addr_o` equals the current pointer in that cycle, and the pointer then drops by one, wrapping from 0x0000 to 0xFFFF.
- R3: With `pull_i` as the only strobe, `addr_o` equals the pointer plus one in that cycle, and the pointer then takes that value, wrapping from 0xFFFF to 0x0000.
- R4: With `add_i` as the only strobe, the pointer becomes the pointer plus `imm_i` taken as a two's-complement byte sign-extended to 16 bits. The sum is modulo 2^16.
- R5: When `load_i` is high, the pointer becomes `load_val_i` at the next edge, even if other strobes are also high, and `collide_o` stays low.
- R6: With `lowrst_i` as the only strobe, the low byte of the pointer becomes 0xFF and the high byte is left unchanged.
- R7: When `load_i` is low and two or more of `push_i`, `pull_i`, `add_i` and `lowrst_i` are high, `collide_o` is high in that cycle, `addr_o` shows the current pointer, and the pointer does not change.
- R8: With no strobe raised, the pointer holds, and `addr_o` equals `sp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Stack store strobe: use the pointer, then decrement it |
| pull_i | input | 1 | Stack read strobe: increment the pointer, then use it |
| add_i | input | 1 | Add the sign-extended immediate to the pointer |
| load_i | input | 1 | Load the full pointer from load_val_i |
| lowrst_i | input | 1 | Set the low byte of the pointer to 0xFF |
| imm_i | input | 8 | Signed offset for add_i |
| load_val_i | input | 16 | Value for load_i |
| addr_o | output | 16 | Stack access address for the current cycle |
| sp_o | output | 16 | Registered pointer value |
| collide_o | output | 1 | Illegal strobe overlap seen this cycle |

## Verification
A wrong pointer value shows on `sp_o` one edge after the operation that produced it, and it also shows at once on `addr_o` in any cycle without a pull. A mistake in the push or pull address ordering appears on `addr_o` in the same cycle as the strobe, off by one from the expected value. A decode fault shows either as `collide_o` set or clear in the wrong cycle, or as a pointer that moved when it should have held. Carry into the high byte is exercised through offsets that cross a 256-byte boundary and both wrap points of the 16-bit space, so a wrong sign extension or a truncated carry changes `sp_o` after one edge.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    SP_HOLD   = 3'd0,
    SP_LOAD   = 3'd1,
    SP_PUSH   = 3'd2,
    SP_PULL   = 3'd3,
    SP_ADD    = 3'd4,
    SP_LOWRST = 3'd5
  } sp_op_e;
endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode
  import sp_pkg::*;
(
  input  logic   load_i,
  input  logic   push_i,
  input  logic   pull_i,
  input  logic   add_i,
  input  logic   lowrst_i,
  output sp_op_e op_o,
  output logic   collide_o
);
  logic [3:0] minor;
  logic       multi;

  assign minor = {push_i, pull_i, add_i, lowrst_i};
  assign multi = (minor & (minor - 4'd1)) != 4'd0;

  always_comb begin
    collide_o = 1'b0;
    op_o      = SP_HOLD;
    if (load_i) begin
      op_o = SP_LOAD;
    end else if (multi) begin
      collide_o = 1'b1;
    end else begin
      unique case (1'b1)
        push_i:   op_o = SP_PUSH;
        pull_i:   op_o = SP_PULL;
        add_i:    op_o = SP_ADD;
        lowrst_i: op_o = SP_LOWRST;
        default:  op_o = SP_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/sp_next_calc.sv
module sp_next_calc
  import sp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IW    = 8,
  parameter int LOW_W = 8
) (
  input  sp_op_e        op_i,
  input  logic [AW-1:0] sp_i,
  input  logic [IW-1:0] imm_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] next_o,
  output logic [AW-1:0] addr_o
);
  localparam int EXT_W = AW - IW;

  logic [AW-1:0] inc_v;
  logic [AW-1:0] dec_v;
  logic [AW-1:0] ofs_v;

  assign inc_v = sp_i + AW'(1);
  assign dec_v = sp_i - AW'(1);
  assign ofs_v = {{EXT_W{imm_i[IW-1]}}, imm_i};

  always_comb begin
    next_o = sp_i;
    unique case (op_i)
      SP_LOAD:   next_o = load_val_i;
      SP_PUSH:   next_o = dec_v;
      SP_PULL:   next_o = inc_v;
      SP_ADD:    next_o = sp_i + ofs_v;
      SP_LOWRST: next_o = {sp_i[AW-1:LOW_W], {LOW_W{1'b1}}};
      default:   next_o = sp_i;
    endcase
  end

  assign addr_o = (op_i == SP_PULL) ? inc_v : sp_i;
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          IW        = 8,
  parameter int          LOW_W     = 8,
  parameter logic [15:0] RESET_VAL = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pull_i,
  input  logic          add_i,
  input  logic          load_i,
  input  logic          lowrst_i,
  input  logic [IW-1:0] imm_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] sp_o,
  output logic          collide_o
);
  sp_op_e        op;
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_d;

  sp_op_decode u_dec (
    .load_i    (load_i),
    .push_i    (push_i),
    .pull_i    (pull_i),
    .add_i     (add_i),
    .lowrst_i  (lowrst_i),
    .op_o      (op),
    .collide_o (collide_o)
  );

  sp_next_calc #(.AW(AW), .IW(IW), .LOW_W(LOW_W)) u_calc (
    .op_i       (op),
    .sp_i       (sp_q),
    .imm_i      (imm_i),
    .load_val_i (load_val_i),
    .next_o     (sp_d),
    .addr_o     (addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) sp_q <= AW'(RESET_VAL);
    else     sp_q <= sp_d;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk #(
  parameter int AW    = 16,
  parameter int IW    = 8,
  parameter int LOW_W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          pull_i,
  input logic          add_i,
  input logic          load_i,
  input logic          lowrst_i,
  input logic [IW-1:0] imm_i,
  input logic [AW-1:0] load_val_i,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] sp_o,
  input logic          collide_o
);
  logic [4:0] stb;
  logic [3:0] minor;
  assign stb   = {load_i, push_i, pull_i, add_i, lowrst_i};
  assign minor = {push_i, pull_i, add_i, lowrst_i};

  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> sp_o == AW'(16'h00FF));

  a_r2_push_addr: assert property (@(posedge clk) disable iff (rst)
    stb == 5'b01000 |-> addr_o == sp_o);
  a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
    stb == 5'b01000 |=> sp_o == $past(sp_o) - AW'(1));

  a_r3_pull_addr: assert property (@(posedge clk) disable iff (rst)
    stb == 5'b00100 |-> addr_o == sp_o + AW'(1));
  a_r3_pull_step: assert property (@(posedge clk) disable iff (rst)
    stb == 5'b00100 |=> sp_o == $past(addr_o));

  a_r4_add_offset: assert property (@(posedge clk) disable iff (rst)
    stb == 5'b00010 |=>
      sp_o == $past(sp_o) + {{(AW-IW){$past(imm_i[IW-1])}}, $past(imm_i)});

  a_r5_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_i |=> sp_o == $past(load_val_i));
  a_r5_load_no_flag: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !collide_o);

  a_r6_low_only: assert property (@(posedge clk) disable iff (rst)
    stb == 5'b00001 |=>
      sp_o[AW-1:LOW_W] == $past(sp_o[AW-1:LOW_W]) && sp_o[LOW_W-1:0] == {LOW_W{1'b1}});

  a_r7_flag: assert property (@(posedge clk) disable iff (rst)
    collide_o == (!load_i && $countones(minor) > 1));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    collide_o |=> $stable(sp_o));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    stb == 5'b00000 |=> $stable(sp_o));
endmodule

bind stack_ptr_unit sp_unit_chk #(.AW(AW), .IW(IW), .LOW_W(LOW_W)) chk_i (
  .clk(clk), .rst(rst), .push_i(push_i), .pull_i(pull_i), .add_i(add_i),
  .load_i(load_i), .lowrst_i(lowrst_i), .imm_i(imm_i), .load_val_i(load_val_i),
  .addr_o(addr_o), .sp_o(sp_o), .collide_o(collide_o)
);

// File: tb/stack_ptr_unit_tb_top.sv
module stack_ptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 1'b0, pull_i = 1'b0, add_i = 1'b0, load_i = 1'b0, lowrst_i = 1'b0;
  logic [7:0]  imm_i = 8'h00;
  logic [15:0] load_val_i = 16'h0000;
  logic [15:0] addr_o, sp_o;
  logic        collide_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  stack_ptr_unit dut_i (
    .clk(clk), .rst(rst), .push_i(push_i), .pull_i(pull_i), .add_i(add_i),
    .load_i(load_i), .lowrst_i(lowrst_i), .imm_i(imm_i), .load_val_i(load_val_i),
    .addr_o(addr_o), .sp_o(sp_o), .collide_o(collide_o)
  );

  // Fields: req[4] strobes{load,push,pull,add,lowrst}[5] imm[8] ld[16] exp_addr[16] exp_sp[16] exp_col[1]
  localparam int NV = 18;
  localparam logic [65:0] VEC [NV] = '{
    {4'd8, 5'b00000, 8'h00, 16'h0000, 16'h00FF, 16'h00FF, 1'b0}, // R8 idle
    {4'd2, 5'b01000, 8'h00, 16'h0000, 16'h00FF, 16'h00FE, 1'b0}, // R2 push
    {4'd3, 5'b00100, 8'h00, 16'h0000, 16'h00FF, 16'h00FF, 1'b0}, // R3 pull
    {4'd4, 5'b00010, 8'h10, 16'h0000, 16'h00FF, 16'h010F, 1'b0}, // R4 carry into high byte
    {4'd4, 5'b00010, 8'hF0, 16'h0000, 16'h010F, 16'h00FF, 1'b0}, // R4 negative offset
    {4'd5, 5'b10000, 8'h00, 16'h1234, 16'h00FF, 16'h1234, 1'b0}, // R5 load
    {4'd6, 5'b00001, 8'h00, 16'h0000, 16'h1234, 16'h12FF, 1'b0}, // R6 low byte only
    {4'd4, 5'b00010, 8'h80, 16'h0000, 16'h12FF, 16'h127F, 1'b0}, // R4 most negative
    {4'd4, 5'b00010, 8'h7F, 16'h0000, 16'h127F, 16'h12FE, 1'b0}, // R4 most positive
    {4'd7, 5'b01100, 8'h00, 16'h0000, 16'h12FE, 16'h12FE, 1'b1}, // R7 push+pull
    {4'd5, 5'b11010, 8'h33, 16'hABCD, 16'h12FE, 16'hABCD, 1'b0}, // R5 load beats others
    {4'd7, 5'b00011, 8'h05, 16'h0000, 16'hABCD, 16'hABCD, 1'b1}, // R7 add+lowrst
    {4'd5, 5'b10000, 8'h00, 16'h0000, 16'hABCD, 16'h0000, 1'b0}, // R5 load zero
    {4'd2, 5'b01000, 8'h00, 16'h0000, 16'h0000, 16'hFFFF, 1'b0}, // R2 wrap down
    {4'd3, 5'b00100, 8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R3 wrap up
    {4'd5, 5'b10000, 8'h00, 16'hFFF0, 16'h0000, 16'hFFF0, 1'b0}, // R5 load
    {4'd4, 5'b00010, 8'h20, 16'h0000, 16'hFFF0, 16'h0010, 1'b0}, // R4 wrap up
    {4'd4, 5'b00010, 8'hE0, 16'h0000, 16'h0010, 16'hFFF0, 1'b0}  // R4 wrap down
  };

  task automatic check16(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] s, input logic [7:0] imm, input logic [15:0] ld);
    {load_i, push_i, pull_i, add_i, lowrst_i} = s;
    imm_i = imm;
    load_val_i = ld;
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check16(1, "sp after reset", sp_o, 16'h00FF);   // R1
    check16(1, "addr after reset", addr_o, 16'h00FF); // R1
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [65:0] v;
      v = VEC[i];
      drive(v[61:57], v[56:49], v[48:33]);
      #2;
      check16(int'(v[65:62]), "addr", addr_o, v[32:17]);
      check16(int'(v[65:62]), "collide", {15'd0, collide_o}, {15'd0, v[0]});
      @(posedge clk); #2;
      check16(int'(v[65:62]), "sp", sp_o, v[16:1]);
      @(negedge clk);
    end

    // R3 pull at the top of the space, address shows the wrapped value
    drive(5'b10000, 8'h00, 16'hFFFF);
    @(posedge clk); @(negedge clk);
    drive(5'b00100, 8'h00, 16'h0000);
    #2 check16(3, "pull addr at top", addr_o, 16'h0000);
    @(posedge clk); #2 check16(3, "pull sp at top", sp_o, 16'h0000);
    @(negedge clk);

    // R6 on a value whose low byte is already clear keeps a nonzero high byte
    drive(5'b10000, 8'h00, 16'h8000);
    @(posedge clk); @(negedge clk);
    drive(5'b00001, 8'h00, 16'h0000);
    @(posedge clk); #2 check16(6, "low reset high byte", sp_o, 16'h80FF);
    @(negedge clk);

    // R8 idle with data inputs moving: nothing changes
    drive(5'b00000, 8'h7F, 16'h1111);
    #2 check16(8, "idle addr", addr_o, 16'h80FF);
    @(posedge clk); #2 check16(8, "idle sp", sp_o, 16'h80FF);
    @(negedge clk);

    // R1 reset overrides a raised strobe
    drive(5'b01000, 8'h00, 16'h0000);
    rst = 1'b1;
    @(posedge clk); #2 check16(1, "reset beats push", sp_o, 16'h00FF);
    @(negedge clk);
    rst = 1'b0;
    drive(5'b00000, 8'h00, 16'h0000);
    @(posedge clk); #2 check16(1, "after reset", sp_o, 16'h00FF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule